// File: doc/BRIEF.md
# Bit-Serial Memory Bus Sequencer

This block is a host-side controller for a nonvolatile memory that talks over one data bit, gated by chip enable, output enable and write enable. The memory reads each bus read or write as one protocol bit. The controller takes byte-level requests and expands them into those single-bit strobes. A request carries a start address, a byte count and a direction. Write data arrives on a valid/ready byte stream, and read data leaves on another valid/ready byte stream.

Every accepted request opens with a three-cycle initialisation pattern and then a 16-bit address. A write then shifts its bytes out. It ends with the three-cycle pattern that launches the internal nonvolatile write, and then polls the data line until the memory signals completion. A read shifts bits in, most significant bit first, and packs them into bytes. The protocol is fully static, so a stall on either byte stream simply holds chip enable low with no strobe active. Strobe low time and the minimum high time are set in clock cycles. A configurable poll limit guards against a memory that never finishes.

Top module: `bitbus_host`

## Requirements
- R1: Each accepted request begins with three bus cycles in this order: a read, a write carrying 0, and a read.
- R2: Sixteen address write cycles follow the initialisation, most significant bit first. The topmost bit is always sent as 0, whatever the requested address holds.
- R3: For a write, each byte is taken from the write stream and sent as eight write cycles, MSB first. After the last byte come a read, a write carrying 1, and a read.
- R4: After the launch pattern, read cycles repeat until one samples the data line as 1. `op_done` is then pulsed for one clock with `op_err` low.
- R5: For a read, each byte is assembled from eight read cycles, the first sampled bit going to bit 7. The byte is offered on `rd_data` with `rd_valid` and held unchanged until `rd_ready`. A read of zero bytes ends right after the address.
- R6: A strobe stays low for exactly LOW_CYC clocks. It stays high for at least HIGH_CYC clocks before the next strobe. The two strobes are never low together, and a strobe only falls after the sequencer has issued a cycle.
- R7: `mem_dq_oe` is high during every clock in which `mem_we_n` is low, and low during every clock in which `mem_oe_n` is low.
- R8: `mem_ce_n` is low whenever either strobe is low, and high while the block is idle.
- R9: A write request with a count of 0 or more than PAGE_BYTES produces no bus cycle. It is answered with `op_done` and `op_err` both high.
- R10: With POLL_LIMIT above 0, if POLL_LIMIT consecutive poll reads all return 0, no further poll is made. `op_done` and `op_err` are then pulsed together.
- R11: During and right after reset, all three bus controls are high, `mem_dq_oe`, `rd_valid` and `op_done` are low, and `req_ready` is high. `req_ready` is low while a request is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken when both high |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | 16 | Start address (top bit ignored) |
| req_count | input | CNT_W | Number of bytes |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte taken when both high |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Read byte consumed when both high |
| rd_data | output | 8 | Read byte |
| op_done | output | 1 | One-clock end-of-request pulse |
| op_err | output | 1 | Error qualifier, valid with op_done |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dq_out | output | 1 | Data bit driven to the memory |
| mem_dq_oe | output | 1 | Output enable for the data bit driver |
| mem_dq_in | input | 1 | Data bit sampled from the memory |

## Verification
The bench builds the block with LOW_CYC=3 and HIGH_CYC=2, so strobe widths can be checked exactly against small counts. PAGE_BYTES is reduced to 4, so a full-page write and the one-over rejection both stay a few dozen bit cycles long. POLL_LIMIT is set to 20, which makes the timeout path reachable: the bench modelled memory holds the data line at 0 and the bench counts the exact number of polls before the error. An 8-bit count lets the bench exercise the zero-count read and the zero-count write rejection.

// File: rtl/bbs_pkg.sv
package bbs_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_HIGH
    } cyc_phase_e;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_INIT,
        SQ_ADDR,
        SQ_WLOAD,
        SQ_WBITS,
        SQ_LAUNCH,
        SQ_POLL,
        SQ_RBITS,
        SQ_RHOLD,
        SQ_DONE
    } seq_state_e;

endpackage

// File: rtl/bbs_cycle.sv
module bbs_cycle
    import bbs_pkg::*;
#(
    parameter int LOW_CYC  = 5,
    parameter int HIGH_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic is_write,
    input  logic wbit,
    input  logic dq_in,
    output logic fin,
    output logic rbit,
    output logic oe_n,
    output logic we_n,
    output logic dq_out,
    output logic dq_oe
);

    localparam int CMAX = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
    localparam int CW   = (CMAX > 1) ? $clog2(CMAX + 1) : 1;
    localparam logic [CW-1:0] LOW_LOAD  = CW'(LOW_CYC - 1);
    localparam logic [CW-1:0] HIGH_LOAD = CW'(HIGH_CYC - 1);

    typedef struct packed {
        cyc_phase_e      phase;
        logic [CW-1:0]   cnt;
        logic            wr;
        logic            obit;
        logic            ibit;
    } cyc_state_t;

    cyc_state_t cs_d, cs_q;

    always_comb begin
        cs_d = cs_q;
        unique case (cs_q.phase)
            PH_IDLE: begin
                if (start) begin
                    cs_d.phase = PH_LOW;
                    cs_d.cnt   = LOW_LOAD;
                    cs_d.wr    = is_write;
                    cs_d.obit  = wbit;
                end
            end
            PH_LOW: begin
                if (cs_q.cnt == '0) begin
                    cs_d.ibit  = dq_in;
                    cs_d.phase = PH_HIGH;
                    cs_d.cnt   = HIGH_LOAD;
                end else begin
                    cs_d.cnt = cs_q.cnt - 1'b1;
                end
            end
            PH_HIGH: begin
                if (cs_q.cnt == '0) begin
                    cs_d.phase = PH_IDLE;
                end else begin
                    cs_d.cnt = cs_q.cnt - 1'b1;
                end
            end
            default: cs_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q <= '{phase: PH_IDLE, cnt: '0, wr: 1'b0, obit: 1'b0, ibit: 1'b0};
        end else begin
            cs_q <= cs_d;
        end
    end

    assign fin    = (cs_q.phase == PH_HIGH) && (cs_q.cnt == '0);
    assign rbit   = cs_q.ibit;
    assign oe_n   = !((cs_q.phase == PH_LOW) && !cs_q.wr);
    assign we_n   = !((cs_q.phase == PH_LOW) && cs_q.wr);
    assign dq_out = cs_q.obit;
    assign dq_oe  = cs_q.wr && (cs_q.phase != PH_IDLE);

    logic strobe_low;
    assign strobe_low = !oe_n || !we_n;

    assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n));

    assert_strobe_needs_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_low) |-> $past(start));

    assert_read_undriven_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> !dq_oe);

endmodule

// File: rtl/bbs_seq.sv
module bbs_seq
    import bbs_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int PAGE_BYTES = 64,
    parameter int POLL_LIMIT = 65535
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [15:0]      req_addr,
    input  logic [CNT_W-1:0] req_count,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [7:0]       wr_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [7:0]       rd_data,
    output logic             op_done,
    output logic             op_err,
    output logic             ce_n,
    output logic             cyc_start,
    output logic             cyc_write,
    output logic             cyc_wbit,
    input  logic             cyc_fin,
    input  logic             cyc_rbit
);

    localparam int POLL_W = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
    localparam logic [CNT_W-1:0] PAGE_LIM = CNT_W'(PAGE_BYTES);

    typedef struct packed {
        seq_state_e        st;
        logic              inflight;
        logic [3:0]        step;
        logic [CNT_W-1:0]  left;
        logic [7:0]        shreg;
        logic [15:0]       addr;
        logic [POLL_W-1:0] polls;
        logic              wr;
        logic              err;
    } seq_t;

    seq_t sq_d, sq_q;
    logic poll_expire;
    logic issuing;
    logic adv;

    generate
        if (POLL_LIMIT > 0) begin : g_timeout
            localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLL_LIMIT - 1);
            assign poll_expire = (sq_q.polls == POLL_LAST);
        end else begin : g_no_timeout
            assign poll_expire = 1'b0;
        end
    endgenerate

    assign issuing = (sq_q.st == SQ_INIT)   || (sq_q.st == SQ_ADDR) ||
                     (sq_q.st == SQ_WBITS)  || (sq_q.st == SQ_LAUNCH) ||
                     (sq_q.st == SQ_POLL)   || (sq_q.st == SQ_RBITS);
    assign adv = issuing && sq_q.inflight && cyc_fin;

    always_comb begin
        sq_d      = sq_q;
        req_ready = 1'b0;
        wr_ready  = 1'b0;
        rd_valid  = 1'b0;
        cyc_start = 1'b0;
        cyc_write = 1'b0;
        cyc_wbit  = 1'b0;

        if (issuing) begin
            if (!sq_q.inflight) begin
                cyc_start     = 1'b1;
                sq_d.inflight = 1'b1;
            end else if (cyc_fin) begin
                sq_d.inflight = 1'b0;
            end
        end

        unique case (sq_q.st)
            SQ_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    sq_d.wr   = req_write;
                    sq_d.left = req_count;
                    sq_d.addr = req_addr & 16'h7FFF;
                    sq_d.step = '0;
                    if (req_write && ((req_count == '0) || (req_count > PAGE_LIM))) begin
                        sq_d.st  = SQ_DONE;
                        sq_d.err = 1'b1;
                    end else begin
                        sq_d.st  = SQ_INIT;
                        sq_d.err = 1'b0;
                    end
                end
            end
            SQ_INIT: begin
                cyc_write = (sq_q.step == 4'd1);
                if (adv) begin
                    if (sq_q.step == 4'd2) begin
                        sq_d.st   = SQ_ADDR;
                        sq_d.step = '0;
                    end else begin
                        sq_d.step = sq_q.step + 4'd1;
                    end
                end
            end
            SQ_ADDR: begin
                cyc_write = 1'b1;
                cyc_wbit  = sq_q.addr[15];
                if (adv) begin
                    sq_d.addr = {sq_q.addr[14:0], 1'b0};
                    sq_d.step = sq_q.step + 4'd1;
                    if (sq_q.step == 4'd15) begin
                        sq_d.step = '0;
                        if (sq_q.wr) begin
                            sq_d.st = SQ_WLOAD;
                        end else if (sq_q.left == '0) begin
                            sq_d.st = SQ_DONE;
                        end else begin
                            sq_d.st = SQ_RBITS;
                        end
                    end
                end
            end
            SQ_WLOAD: begin
                wr_ready = 1'b1;
                if (wr_valid) begin
                    sq_d.shreg = wr_data;
                    sq_d.left  = sq_q.left - 1'b1;
                    sq_d.st    = SQ_WBITS;
                    sq_d.step  = '0;
                end
            end
            SQ_WBITS: begin
                cyc_write = 1'b1;
                cyc_wbit  = sq_q.shreg[7];
                if (adv) begin
                    sq_d.shreg = {sq_q.shreg[6:0], 1'b0};
                    sq_d.step  = sq_q.step + 4'd1;
                    if (sq_q.step == 4'd7) begin
                        sq_d.step = '0;
                        sq_d.st   = (sq_q.left == '0) ? SQ_LAUNCH : SQ_WLOAD;
                    end
                end
            end
            SQ_LAUNCH: begin
                cyc_write = (sq_q.step == 4'd1);
                cyc_wbit  = 1'b1;
                if (adv) begin
                    if (sq_q.step == 4'd2) begin
                        sq_d.st    = SQ_POLL;
                        sq_d.step  = '0;
                        sq_d.polls = '0;
                    end else begin
                        sq_d.step = sq_q.step + 4'd1;
                    end
                end
            end
            SQ_POLL: begin
                if (adv) begin
                    if (cyc_rbit) begin
                        sq_d.st = SQ_DONE;
                    end else if (poll_expire) begin
                        sq_d.st  = SQ_DONE;
                        sq_d.err = 1'b1;
                    end else begin
                        sq_d.polls = sq_q.polls + 1'b1;
                    end
                end
            end
            SQ_RBITS: begin
                if (adv) begin
                    sq_d.shreg = {sq_q.shreg[6:0], cyc_rbit};
                    sq_d.step  = sq_q.step + 4'd1;
                    if (sq_q.step == 4'd7) begin
                        sq_d.st = SQ_RHOLD;
                    end
                end
            end
            SQ_RHOLD: begin
                rd_valid = 1'b1;
                if (rd_ready) begin
                    sq_d.left = sq_q.left - 1'b1;
                    sq_d.step = '0;
                    sq_d.st   = (sq_q.left == CNT_W'(1)) ? SQ_DONE : SQ_RBITS;
                end
            end
            SQ_DONE: begin
                sq_d.st = SQ_IDLE;
            end
            default: sq_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q <= '{st: SQ_IDLE, inflight: 1'b0, step: '0, left: '0, shreg: '0,
                      addr: '0, polls: '0, wr: 1'b0, err: 1'b0};
        end else begin
            sq_q <= sq_d;
        end
    end

    assign rd_data = sq_q.shreg;
    assign op_done = (sq_q.st == SQ_DONE);
    assign op_err  = (sq_q.st == SQ_DONE) && sq_q.err;
    assign ce_n    = (sq_q.st == SQ_IDLE) || (sq_q.st == SQ_DONE);

    assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !op_done);

    assert_idle_no_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!cyc_start && !rd_valid && !wr_ready));

endmodule

// File: rtl/bitbus_host.sv
module bitbus_host #(
    parameter int LOW_CYC    = 5,
    parameter int HIGH_CYC   = 5,
    parameter int CNT_W      = 16,
    parameter int PAGE_BYTES = 64,
    parameter int POLL_LIMIT = 65535
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [15:0]      req_addr,
    input  logic [CNT_W-1:0] req_count,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [7:0]       wr_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [7:0]       rd_data,
    output logic             op_done,
    output logic             op_err,
    output logic             mem_ce_n,
    output logic             mem_oe_n,
    output logic             mem_we_n,
    output logic             mem_dq_out,
    output logic             mem_dq_oe,
    input  logic             mem_dq_in
);

    logic cyc_start;
    logic cyc_write;
    logic cyc_wbit;
    logic cyc_fin;
    logic cyc_rbit;

    bbs_seq #(
        .CNT_W      (CNT_W),
        .PAGE_BYTES (PAGE_BYTES),
        .POLL_LIMIT (POLL_LIMIT)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_count  (req_count),
        .wr_valid   (wr_valid),
        .wr_ready   (wr_ready),
        .wr_data    (wr_data),
        .rd_valid   (rd_valid),
        .rd_ready   (rd_ready),
        .rd_data    (rd_data),
        .op_done    (op_done),
        .op_err     (op_err),
        .ce_n       (mem_ce_n),
        .cyc_start  (cyc_start),
        .cyc_write  (cyc_write),
        .cyc_wbit   (cyc_wbit),
        .cyc_fin    (cyc_fin),
        .cyc_rbit   (cyc_rbit)
    );

    bbs_cycle #(
        .LOW_CYC  (LOW_CYC),
        .HIGH_CYC (HIGH_CYC)
    ) u_cycle (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cyc_start),
        .is_write (cyc_write),
        .wbit     (cyc_wbit),
        .dq_in    (mem_dq_in),
        .fin      (cyc_fin),
        .rbit     (cyc_rbit),
        .oe_n     (mem_oe_n),
        .we_n     (mem_we_n),
        .dq_out   (mem_dq_out),
        .dq_oe    (mem_dq_oe)
    );

    assert_ce_covers_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || !mem_we_n) |-> !mem_ce_n);

    assert_write_driven_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe);

endmodule

// File: tb/bitbus_host_test.sv
`timescale 1ns/1ps
module bitbus_host_test;

    localparam int LOW_CYC    = 3;
    localparam int HIGH_CYC   = 2;
    localparam int CNT_W      = 8;
    localparam int PAGE_BYTES = 4;
    localparam int POLL_LIMIT = 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic             req_write = 1'b0;
    logic [15:0]      req_addr = '0;
    logic [CNT_W-1:0] req_count = '0;
    logic             wr_valid = 1'b0;
    logic             wr_ready;
    logic [7:0]       wr_data = '0;
    logic             rd_valid;
    logic             rd_ready = 1'b0;
    logic [7:0]       rd_data;
    logic             op_done;
    logic             op_err;
    logic             mem_ce_n;
    logic             mem_oe_n;
    logic             mem_we_n;
    logic             mem_dq_out;
    logic             mem_dq_oe;
    logic             mem_dq_in = 1'b0;

    always #10 clk = ~clk;

    bitbus_host #(
        .LOW_CYC    (LOW_CYC),
        .HIGH_CYC   (HIGH_CYC),
        .CNT_W      (CNT_W),
        .PAGE_BYTES (PAGE_BYTES),
        .POLL_LIMIT (POLL_LIMIT)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_count  (req_count),
        .wr_valid   (wr_valid),
        .wr_ready   (wr_ready),
        .wr_data    (wr_data),
        .rd_valid   (rd_valid),
        .rd_ready   (rd_ready),
        .rd_data    (rd_data),
        .op_done    (op_done),
        .op_err     (op_err),
        .mem_ce_n   (mem_ce_n),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .mem_dq_in  (mem_dq_in)
    );

    int vectors = 0;
    int miscompares = 0;

    bit    ev_kind[$];
    bit    ev_bit[$];
    string ev_tag[$];
    logic [7:0] wr_q[$];
    logic [7:0] rd_q[$];

    bit done_seen = 1'b0;
    bit done_err  = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic ev(input bit kind, input bit b, input string tag);
        ev_kind.push_back(kind);
        ev_bit.push_back(b);
        ev_tag.push_back(tag);
    endtask

    task automatic push_init();
        ev(1'b0, 1'b0, "R1");
        ev(1'b1, 1'b0, "R1");
        ev(1'b0, 1'b0, "R1");
    endtask

    task automatic push_addr(input logic [15:0] a);
        for (int i = 15; i >= 0; i--) begin
            ev(1'b1, (i == 15) ? 1'b0 : a[i], "R2");
        end
    endtask

    task automatic push_wbyte(input logic [7:0] b);
        wr_q.push_back(b);
        for (int i = 7; i >= 0; i--) ev(1'b1, b[i], "R3");
    endtask

    task automatic push_launch();
        ev(1'b0, 1'b0, "R3");
        ev(1'b1, 1'b1, "R3");
        ev(1'b0, 1'b0, "R3");
    endtask

    task automatic push_polls(input int zeros, input bit finish);
        for (int i = 0; i < zeros; i++) ev(1'b0, 1'b0, finish ? "R4" : "R10");
        if (finish) ev(1'b0, 1'b1, "R4");
    endtask

    task automatic push_rbyte(input logic [7:0] b);
        rd_q.push_back(b);
        for (int i = 7; i >= 0; i--) ev(1'b0, b[i], "R5");
    endtask

    // Behavioural memory model and per-clock comparison
    initial begin
        bit   prev_low  = 1'b0;
        int   low_cnt   = 0;
        int   high_cnt  = 1000;
        int   cyc       = 0;
        bit   hold_prev = 1'b0;
        logic [7:0] prev_data = '0;
        forever begin
            @(negedge clk);
            cyc++;
            if (rst_n) begin
                bit s_low;
                s_low = !mem_oe_n || !mem_we_n;
                chk(!(!mem_oe_n && !mem_we_n), "R6", "both strobes low", 1, 0);
                if (!mem_oe_n) chk(!mem_dq_oe, "R7", "driving during read", mem_dq_oe, 0);
                if (!mem_we_n) chk(mem_dq_oe, "R7", "not driving during write", mem_dq_oe, 1);
                if (s_low) chk(!mem_ce_n, "R8", "chip enable during strobe", mem_ce_n, 0);
                if (s_low && !prev_low) begin
                    chk(high_cnt >= HIGH_CYC, "R6", "high time", high_cnt, HIGH_CYC);
                    if (ev_kind.size() == 0) begin
                        chk(1'b0, "R9", "unexpected bus cycle", int'(!mem_we_n), 0);
                    end else begin
                        chk(!mem_we_n == ev_kind[0], ev_tag[0], "cycle kind",
                            int'(!mem_we_n), int'(ev_kind[0]));
                        if (ev_kind[0])
                            chk(mem_dq_out == ev_bit[0], ev_tag[0], "write bit",
                                mem_dq_out, ev_bit[0]);
                    end
                    low_cnt = 0;
                end
                if (s_low) low_cnt++;
                if (!s_low && prev_low) begin
                    chk(low_cnt == LOW_CYC, "R6", "low time", low_cnt, LOW_CYC);
                    if (ev_kind.size() > 0) begin
                        void'(ev_kind.pop_front());
                        void'(ev_bit.pop_front());
                        void'(ev_tag.pop_front());
                    end
                    high_cnt = 0;
                end
                if (!s_low) high_cnt++;
                if (op_done) begin
                    done_seen = 1'b1;
                    done_err  = op_err;
                end
                prev_low = s_low;
            end

            mem_dq_in = (ev_kind.size() > 0 && !ev_kind[0]) ? ev_bit[0] : 1'b0;
            wr_valid  = (wr_q.size() > 0);
            wr_data   = (wr_q.size() > 0) ? wr_q[0] : 8'h00;
            rd_ready  = ((cyc % 3) != 1);

            if (rst_n) begin
                if (hold_prev)
                    chk(rd_valid && (rd_data == prev_data), "R5", "held byte",
                        rd_data, prev_data);
                if (wr_valid && wr_ready) void'(wr_q.pop_front());
                if (rd_valid && rd_ready) begin
                    if (rd_q.size() == 0) begin
                        chk(1'b0, "R5", "unexpected read byte", rd_data, 0);
                    end else begin
                        chk(rd_data == rd_q[0], "R5", "read byte", rd_data, rd_q[0]);
                        void'(rd_q.pop_front());
                    end
                end
                hold_prev = rd_valid && !rd_ready;
                prev_data = rd_data;
            end
        end
    end

    task automatic run_op(input bit w, input logic [15:0] a, input int cnt,
                          input bit exp_err, input string tag);
        int t;
        @(negedge clk);
        done_seen = 1'b0;
        req_valid = 1'b1;
        req_write = w;
        req_addr  = a;
        req_count = CNT_W'(cnt);
        @(negedge clk);
        req_valid = 1'b0;
        if (!exp_err || tag != "R9")
            chk(!req_ready, "R11", "ready while busy", req_ready, 0);
        t = 0;
        while (!done_seen && t < 20000) begin
            @(negedge clk);
            t++;
        end
        chk(done_seen, tag, "done reached", done_seen, 1);
        chk(done_err == exp_err, tag, "error flag", done_err, exp_err);
        chk(ev_kind.size() == 0, tag, "bus cycles left over", ev_kind.size(), 0);
        chk(wr_q.size() == 0, tag, "write bytes left over", wr_q.size(), 0);
        chk(rd_q.size() == 0, tag, "read bytes left over", rd_q.size(), 0);
        @(negedge clk);
        chk(req_ready && mem_ce_n, "R11", "back to idle", req_ready, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not finish, actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n, "R11", "bus idle in reset",
            {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
        chk(!mem_dq_oe && !rd_valid && !op_done, "R11", "outputs quiet in reset",
            {mem_dq_oe, rd_valid, op_done}, 0);
        chk(req_ready, "R11", "ready in reset", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R11", "bus idle after reset",
            {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);

        // Two-byte write, completion after three busy polls (R1 R2 R3 R4)
        push_init(); push_addr(16'h1234);
        push_wbyte(8'hA5); push_wbyte(8'h3C);
        push_launch(); push_polls(3, 1'b1);
        run_op(1'b1, 16'h1234, 2, 1'b0, "R4");

        // Three-byte read, top address bit forced low (R2 R5)
        push_init(); push_addr(16'hFFFF);
        push_rbyte(8'hC3); push_rbyte(8'h5A); push_rbyte(8'hFF);
        run_op(1'b0, 16'hFFFF, 3, 1'b0, "R5");

        // Full page write, immediate completion (R3 R4)
        push_init(); push_addr(16'h0040);
        push_wbyte(8'h01); push_wbyte(8'h80); push_wbyte(8'h00); push_wbyte(8'hFE);
        push_launch(); push_polls(0, 1'b1);
        run_op(1'b1, 16'h0040, PAGE_BYTES, 1'b0, "R3");

        // Over-long and empty writes are rejected without bus activity (R9)
        run_op(1'b1, 16'h0100, PAGE_BYTES + 1, 1'b1, "R9");
        run_op(1'b1, 16'h0100, 0, 1'b1, "R9");

        // Zero-byte read stops after the address (R5)
        push_init(); push_addr(16'h2A55);
        run_op(1'b0, 16'h2A55, 0, 1'b0, "R5");

        // Memory never completes: exactly POLL_LIMIT polls, then error (R10)
        push_init(); push_addr(16'h0007);
        push_wbyte(8'h96);
        push_launch(); push_polls(POLL_LIMIT, 1'b0);
        run_op(1'b1, 16'h0007, 1, 1'b1, "R10");

        // Normal read after the error (R1 R5)
        push_init(); push_addr(16'h0007);
        push_rbyte(8'h69);
        run_op(1'b0, 16'h0007, 1, 1'b0, "R1");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule